// File: doc/BRIEF.md
# Folded Symmetric Decimate-by-3 FIR Filter

This block is a 24-tap linear-phase FIR filter for a single channel of 10-bit signed samples. It produces one output for every three accepted input samples. The impulse response has even symmetry, so only twelve coefficients are held. Each coefficient weights a mirrored pair of history samples. That pair is summed in a pre-adder before it reaches a multiplier.

Four multiply lanes run in parallel, and the three coefficient phases share them. Each accepted sample advances a phase counter. At every phase, each lane adds one mirrored pair and multiplies the sum by the coefficient that the phase selects. An accumulator starts a fresh sum on phase 0, adds the products of phases 1 and 2, and moves the finished result to a registered output after phase 2. Coefficients are written through a small write port while the filter is idle.

Top module: `sym_decim_fir`

## Requirements
- R1: Reset (rst high at a rising edge) drives out_valid low and out_data to zero, and clears the sample history and the phase counter. Coefficients keep their values. The first outputs after reset treat all earlier samples as zero.
- R2: The phase counter advances 0, 1, 2, 0 only on cycles where in_valid is high. The first accepted sample after reset is phase 0, and an output is produced only for samples accepted in phase 2.
- R3: For the output made at accepted sample n, out_data equals the sum over k = 0..23 of h[k]·x[n-k], with h[k] = C[min(k, 23-k)]. It is given as a 28-bit two's-complement value with no rounding or truncation.
- R4: Coefficient Ci weights both the sample i steps back and the sample 23-i steps back. A single impulse therefore reveals the mirrored response.
- R5: Each output includes only the products of its own three phases and nothing from earlier output groups.
- R6: out_valid is a one-clock pulse per output. It is registered at the second rising edge after the edge that accepts the phase-2 sample, and it is never high two cycles in a row.
- R7: A write with coef_we high and coef_addr 0..11 stores coef_data (10-bit signed) into C[coef_addr], and later samples use the new value. Writes to addresses 12..15 change nothing.
- R8: When in_valid is low, in_data is ignored. The history does not shift and the phase does not advance.
- R9: Full-scale inputs (all samples and coefficients at -512) produce the exact result 6291456 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; in_data is accepted on this cycle |
| in_data | input | 10 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Coefficient index, 0..11 valid |
| coef_data | input | 10 | Signed coefficient value |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 28 | Signed full-precision filter output |

## Verification
A wrong phase count or a misrouted tap shows up at the first output it touches. That output is the one after the phase-2 sample, two clocks after it is accepted. A phase slip also moves out_valid to the wrong sample, which the bench catches as a pulse that was not expected or a latency that does not match. Accumulator state carried over from an earlier group appears as a nonzero output once the history has filled with zeros. Impulse tests at the three phase offsets map every coefficient onto a distinct output, so a swapped lane or a swapped phase fails within eight outputs.

// File: rtl/fold_fir_pkg.sv
package fold_fir_pkg;

  // Older-side tap feeding a lane in a given phase (taps[0] = newest sample)
  function automatic int far_tap(int taps, int decim, int ph, int lane);
    return taps - 2 * decim + 1 + 2 * ph - decim * lane;
  endfunction

  // Newer-side tap feeding a lane; the same in every phase
  function automatic int near_tap(int decim, int lane);
    return decim * lane;
  endfunction

  // Coefficient index a lane uses in a given phase
  function automatic int coef_sel(int decim, int ph, int lane);
    return decim - 1 - ph + decim * lane;
  endfunction

endpackage

// File: rtl/fold_tapline.sv
module fold_tapline #(
  parameter int DATA_W = 10,
  parameter int TAPS   = 24,
  parameter int DECIM  = 3,
  parameter int PH_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_data,
  output logic [TAPS-1:0][DATA_W-1:0]   taps,
  output logic [PH_W-1:0]               cur_ph,
  output logic                          step
);

  logic [PH_W-1:0] ph_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      taps   <= '0;
      ph_cnt <= '0;
      cur_ph <= '0;
      step   <= 1'b0;
    end else begin
      step <= in_valid;
      if (in_valid) begin
        taps   <= {taps[TAPS-2:0], in_data};
        cur_ph <= ph_cnt;
        ph_cnt <= (ph_cnt == PH_W'(DECIM - 1)) ? '0 : ph_cnt + 1'b1;
      end
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ph_cnt < PH_W'(DECIM)) && (cur_ph < PH_W'(DECIM))); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ph_cnt)); // R2

  AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> taps[1] == $past(taps[0])); // R8

  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(taps)); // R8

endmodule

// File: rtl/fold_coef_bank.sv
module fold_coef_bank #(
  parameter int COEF_W = 10,
  parameter int NCOEF  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [COEF_W-1:0]             wdata,
  output logic [NCOEF-1:0][COEF_W-1:0]  coefs
);

  // Plain registers: all twelve values are read in parallel every cycle.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NCOEF; i++) begin
      if (we && addr == ADDR_W'(i)) coefs[i] <= wdata;
    end
  end

  AST_COEF_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (we && addr >= ADDR_W'(NCOEF)) |=> $stable(coefs)); // R7

endmodule

// File: rtl/fold_lane.sv
module fold_lane
  import fold_fir_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int COEF_W = 10,
  parameter int TAPS   = 24,
  parameter int DECIM  = 3,
  parameter int PH_W   = 2,
  parameter int NCOEF  = 12,
  parameter int LANE   = 0,
  parameter int PROD_W = DATA_W + 1 + COEF_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic [PH_W-1:0]               ph,
  input  logic [TAPS-1:0][DATA_W-1:0]   taps,
  input  logic [NCOEF-1:0][COEF_W-1:0]  coefs,
  output logic signed [PROD_W-1:0]      prod
);

  localparam int NEAR = near_tap(DECIM, LANE);

  logic [DECIM-1:0][DATA_W-1:0] far_c;
  logic [DECIM-1:0][COEF_W-1:0] coef_c;

  for (genvar p = 0; p < DECIM; p++) begin : g_phase
    localparam int FI = far_tap(TAPS, DECIM, p, LANE);
    localparam int CI = coef_sel(DECIM, p, LANE);
    assign far_c[p]  = taps[FI];
    assign coef_c[p] = coefs[CI];
  end

  logic signed [DATA_W-1:0] far_s, near_s;
  logic signed [COEF_W-1:0] coef_s;
  logic signed [DATA_W:0]   pre;
  logic signed [PROD_W-1:0] pre_x, coef_x;

  always_comb begin
    far_s  = '0;
    coef_s = '0;
    for (int p = 0; p < DECIM; p++) begin
      if (ph == PH_W'(p)) begin
        far_s  = $signed(far_c[p]);
        coef_s = $signed(coef_c[p]);
      end
    end
  end

  assign near_s = $signed(taps[NEAR]);
  assign pre    = (DATA_W + 1)'(far_s) + (DATA_W + 1)'(near_s);
  assign pre_x  = PROD_W'(pre);
  assign coef_x = PROD_W'(coef_s);

  always_ff @(posedge clk) begin
    if (rst)     prod <= '0;
    else if (en) prod <= pre_x * coef_x;
  end

endmodule

// File: rtl/fold_accum.sv
module fold_accum #(
  parameter int PROD_W = 21,
  parameter int LANES  = 4,
  parameter int ACC_W  = 28,
  parameter int DECIM  = 3,
  parameter int PH_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic [PH_W-1:0]               ph,
  input  logic [LANES-1:0][PROD_W-1:0]  prods,
  output logic                          out_valid,
  output logic [ACC_W-1:0]              out_data
);

  logic signed [ACC_W-1:0] acc, lane_sum, acc_nx;

  always_comb begin
    lane_sum = '0;
    for (int l = 0; l < LANES; l++) begin
      lane_sum = lane_sum + ACC_W'($signed(prods[l]));
    end
  end

  // Phase 0 opens a new group: prior contents are discarded.
  assign acc_nx = ((ph == '0) ? '0 : acc) + lane_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (en) begin
        acc <= acc_nx;
        if (ph == PH_W'(DECIM - 1)) begin
          out_valid <= 1'b1;
          out_data  <= acc_nx;
        end
      end
    end
  end

endmodule

// File: rtl/sym_decim_fir.sv
module sym_decim_fir #(
  parameter int DATA_W = 10,
  parameter int COEF_W = 10,
  parameter int TAPS   = 24,
  parameter int DECIM  = 3,
  parameter int ACC_W  = 28,
  parameter int ADDR_W = $clog2(TAPS / 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               coef_we,
  input  logic [ADDR_W-1:0]  coef_addr,
  input  logic [COEF_W-1:0]  coef_data,
  output logic               out_valid,
  output logic [ACC_W-1:0]   out_data
);

  localparam int NCOEF  = TAPS / 2;
  localparam int LANES  = NCOEF / DECIM;
  localparam int PH_W   = (DECIM > 2) ? $clog2(DECIM) : 1;
  localparam int PROD_W = DATA_W + 1 + COEF_W;

  logic [TAPS-1:0][DATA_W-1:0]  taps;
  logic [NCOEF-1:0][COEF_W-1:0] coefs;
  logic [PH_W-1:0]              cur_ph, prod_ph;
  logic                         step, prod_v;
  logic [LANES-1:0][PROD_W-1:0] prods;

  fold_tapline #(.DATA_W(DATA_W), .TAPS(TAPS), .DECIM(DECIM), .PH_W(PH_W)) u_tapline (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .taps(taps), .cur_ph(cur_ph), .step(step)
  );

  fold_coef_bank #(.COEF_W(COEF_W), .NCOEF(NCOEF), .ADDR_W(ADDR_W)) u_coefs (
    .clk(clk), .rst(rst), .we(coef_we), .addr(coef_addr), .wdata(coef_data),
    .coefs(coefs)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PROD_W-1:0] lane_prod;
    fold_lane #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .DECIM(DECIM),
      .PH_W(PH_W), .NCOEF(NCOEF), .LANE(l), .PROD_W(PROD_W)
    ) u_lane (
      .clk(clk), .rst(rst), .en(step), .ph(cur_ph), .taps(taps),
      .coefs(coefs), .prod(lane_prod)
    );
    assign prods[l] = lane_prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_v  <= 1'b0;
      prod_ph <= '0;
    end else begin
      prod_v  <= step;
      prod_ph <= cur_ph;
    end
  end

  fold_accum #(.PROD_W(PROD_W), .LANES(LANES), .ACC_W(ACC_W), .DECIM(DECIM), .PH_W(PH_W)) u_accum (
    .clk(clk), .rst(rst), .en(prod_v), .ph(prod_ph), .prods(prods),
    .out_valid(out_valid), .out_data(out_data)
  );

  AST_XFER_TIMING: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(step, 2) && $past(cur_ph, 2) == PH_W'(DECIM - 1))); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R6

endmodule

// File: tb/sym_decim_fir_tb.sv
module sym_decim_fir_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [9:0]  in_data = '0;
  logic        coef_we = 1'b0;
  logic [3:0]  coef_addr = '0;
  logic [9:0]  coef_data = '0;
  logic        out_valid;
  logic [27:0] out_data;

  always #5 clk = ~clk;

  sym_decim_fir u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R3";
  int coef_m[12];
  int hist_m[24];
  int ph_m = 0;
  int exp_q[$];
  int stamp_q[$];

  function automatic void check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endfunction

  function automatic int hval(int k);
    return coef_m[(k < 12) ? k : 23 - k];
  endfunction

  task automatic send(int x);
    int y;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[9:0];
    for (int k = 23; k > 0; k--) hist_m[k] = hist_m[k-1];
    hist_m[0] = x;
    if (ph_m == 2) begin
      y = 0;
      for (int k = 0; k < 24; k++) y += hval(k) * hist_m[k];
      exp_q.push_back(y);
      stamp_q.push_back(cyc + 3);
    end
    ph_m = (ph_m + 1) % 3;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 10'($urandom);
    end
  endtask

  task automatic wcoef(int a, int v);
    @(negedge clk);
    in_valid  = 1'b0;
    coef_we   = 1'b1;
    coef_addr = 4'(a);
    coef_data = 10'(v);
    if (a < 12) coef_m[a] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_data == '0, "R1", "out_data in reset", int'($signed(out_data)), 0);
    rst = 1'b0;
    for (int k = 0; k < 24; k++) hist_m[k] = 0;
    ph_m = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "out_valid with no phase-2 sample", 1, 0);
      end else begin
        int e, s;
        e = exp_q.pop_front();
        s = stamp_q.pop_front();
        check(int'($signed(out_data)) == e, cur_req, "out_data", int'($signed(out_data)), e);
        check(cyc == s, "R6", "output cycle", cyc, s);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 24; k++) hist_m[k] = 0;
    do_reset();
    for (int i = 0; i < 12; i++) wcoef(i, (i + 1) * 37 - 200);

    // R4: impulse at each phase offset exposes the mirrored response
    for (int s = 0; s < 3; s++) begin
      do_reset();
      cur_req = "R4";
      for (int i = 0; i < 27; i++) send((i == s) ? 100 : 0);
      idle(4);
    end

    // R3: back-to-back random samples
    cur_req = "R3";
    for (int i = 0; i < 60; i++) send($urandom_range(0, 1023) - 512);
    idle(4);

    // R8 / R2: gaps with garbage on in_data
    cur_req = "R8";
    for (int i = 0; i < 45; i++) begin
      send($urandom_range(0, 1023) - 512);
      idle($urandom_range(1, 3));
    end
    idle(4);

    // R1: reset clears history, so zero input gives zero output
    do_reset();
    cur_req = "R1";
    for (int i = 0; i < 9; i++) send(0);
    idle(4);

    // R5: a loud burst then silence must decay to exactly zero
    cur_req = "R5";
    for (int i = 0; i < 24; i++) send(511);
    for (int i = 0; i < 30; i++) send(0);
    idle(4);

    // R7: writes above address 11 are ignored, valid rewrite is used
    for (int a = 12; a < 16; a++) wcoef(a, 300 + a);
    wcoef(5, -77);
    cur_req = "R7";
    for (int i = 0; i < 30; i++) send($urandom_range(0, 1023) - 512);
    idle(4);

    // R9: full-scale extremes
    for (int i = 0; i < 12; i++) wcoef(i, -512);
    cur_req = "R9";
    for (int i = 0; i < 30; i++) send(-512);
    idle(4);
    check(hval(0) * -512 * 24 == 6291456, "R9", "model full scale", hval(0) * -512 * 24, 6291456);
    for (int i = 0; i < 30; i++) send(511);
    idle(6);

    check(exp_q.size() == 0, "R6", "outputs still pending", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule